// File: doc/BRIEF.md
# Per-Instruction Stride Prefetcher

This block watches a stream of load requests. Each request carries the instruction pointer of the load and the byte address it reads. The block keeps a small direct-mapped table that is indexed by instruction pointer. Every entry remembers three things about one load instruction: the address it last touched, the distance between its last two addresses, and a small saturating confidence count.

When the same nonzero distance keeps recurring, the block emits a prefetch for the current address plus that distance. Distances may be positive or negative. Distances larger in magnitude than a fixed limit are never learned.

The prefetch leaves through a valid/ready port that holds one request. If that request is still waiting when a new one is generated, the new one is discarded. Training goes on either way. The cache, the memory fetch and demand-miss handling all sit outside this block.

Top module: `stride_prefetcher`

## Requirements
- R1: After reset `pf_valid` is 0 and no table entry is valid, so the first load of any instruction pointer issues no prefetch.
- R2: A load whose table slot (index = `ld_ip[3:0]`) is empty or holds a different tag (`ld_ip[31:4]`) reallocates that slot. It stores the address, clears the stride and confidence, and issues no prefetch.
- R3: Each instruction pointer trains only its own entry. Interleaved loads from instruction pointers with different indices learn their strides independently.
- R4: A load from a different instruction pointer mapping to the same index evicts the entry. When the evicted pointer returns, it must retrain from scratch.
- R5: On a hit, the new stride is the current address minus the stored address. Confidence (2 bits, saturating at 3) increments when the new stride equals the stored stride and clears otherwise. A prefetch is issued when the updated confidence is at least 2. This first happens on the fourth load of a constant-stride sequence.
- R6: The prefetch address is the load address plus the stride, modulo 2^32. It appears on `pf_addr` with `pf_valid` high in the cycle after the load is accepted. This holds for negative strides as well as positive ones.
- R7: A stride whose magnitude exceeds 2048 bytes is stored as zero and never yields a prefetch. Strides of exactly +2048 and -2048 are tracked.
- R8: A stride of zero never yields a prefetch.
- R9: A prefetch whose address falls in the same 64-byte line as the current load (bits 31:6 equal) is suppressed.
- R10: While `pf_valid` is high and `pf_ready` is low, `pf_valid` and `pf_addr` hold. Prefetches generated meanwhile are dropped, but the table keeps training.
- R11: `pf_valid` falls after a handshake unless a new prefetch is loaded in the same cycle. At most one prefetch is produced per load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | A load request is present this cycle |
| ld_ip | input | 32 | Instruction pointer of the load |
| ld_addr | input | 32 | Byte address of the load |
| pf_valid | output | 1 | Prefetch request pending |
| pf_ready | input | 1 | Consumer accepts the prefetch |
| pf_addr | output | 32 | Prefetch byte address |

## Verification
The assertions assume that `pf_ready` is free to toggle but that `ld_ip` and `ld_addr` matter only when `ld_valid` is high. They assume that loads arrive at most one per cycle, with no backpressure on the load side. The stimulus drives every load for exactly one cycle, between falling edges, and keeps `pf_ready` high except in the stall scenario, where it is lowered across several loads and then raised for a single handshake. The stride sweeps start from a base just below a line boundary, so that both line suppression and address wrap-around occur inside the legal input space.

// File: rtl/stride_prefetcher.sv
module stride_prefetcher #(
  parameter int IP_W        = 32,
  parameter int ADDR_W      = 32,
  parameter int ENTRIES     = 16,
  parameter int MAX_STRIDE  = 2048,
  parameter int CONF_W      = 2,
  parameter int CONF_THRESH = 2,
  parameter int LINE_BYTES  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic [IP_W-1:0]   ld_ip,
  input  logic [ADDR_W-1:0] ld_addr,
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [ADDR_W-1:0] pf_addr
);
  localparam int IDX_W    = $clog2(ENTRIES);
  localparam int TAG_W    = IP_W - IDX_W;
  localparam int STRIDE_W = $clog2(MAX_STRIDE) + 2;
  localparam int LINE_SH  = $clog2(LINE_BYTES);
  localparam logic signed [STRIDE_W-1:0] SMAX = STRIDE_W'(MAX_STRIDE);
  localparam logic [CONF_W-1:0] CMAX = '1;
  localparam logic [CONF_W-1:0] CTH  = CONF_W'(CONF_THRESH);

  logic                 vld_q   [ENTRIES];
  logic [TAG_W-1:0]     tag_q   [ENTRIES];
  logic [ADDR_W-1:0]    last_q  [ENTRIES];
  logic [STRIDE_W-1:0]  strd_q  [ENTRIES];
  logic [CONF_W-1:0]    conf_q  [ENTRIES];

  logic [IDX_W-1:0]     idx;
  logic [TAG_W-1:0]     tag;
  logic                 hit;
  logic [ADDR_W-1:0]    diff;
  logic signed [STRIDE_W-1:0] sdiff;
  logic                 fits, in_range;
  logic [STRIDE_W-1:0]  new_strd;
  logic                 same;
  logic [CONF_W-1:0]    new_conf;
  logic [ADDR_W-1:0]    target;
  logic                 issue, slot_free;

  assign idx   = ld_ip[IDX_W-1:0];
  assign tag   = ld_ip[IP_W-1:IDX_W];
  assign hit   = vld_q[idx] && (tag_q[idx] == tag);
  assign diff  = ld_addr - last_q[idx];
  assign sdiff = $signed(diff[STRIDE_W-1:0]);
  assign fits  = (diff[ADDR_W-1:STRIDE_W-1] == '0) || (diff[ADDR_W-1:STRIDE_W-1] == '1);
  assign in_range = fits && (sdiff <= SMAX) && (sdiff >= -SMAX);
  assign new_strd = in_range ? diff[STRIDE_W-1:0] : '0;
  assign same     = (new_strd == strd_q[idx]);
  assign new_conf = !same ? '0 : (conf_q[idx] == CMAX ? CMAX : conf_q[idx] + 1'b1);
  assign target   = ld_addr + {{(ADDR_W-STRIDE_W){new_strd[STRIDE_W-1]}}, new_strd};
  assign issue    = ld_valid && hit && (new_conf >= CTH) && (new_strd != '0) &&
                    (target[ADDR_W-1:LINE_SH] != ld_addr[ADDR_W-1:LINE_SH]);
  assign slot_free = !pf_valid || pf_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        vld_q[i]  <= 1'b0;
        tag_q[i]  <= '0;
        last_q[i] <= '0;
        strd_q[i] <= '0;
        conf_q[i] <= '0;
      end
    end else if (ld_valid) begin
      vld_q[idx]  <= 1'b1;
      tag_q[idx]  <= tag;
      last_q[idx] <= ld_addr;
      strd_q[idx] <= hit ? new_strd : '0;
      conf_q[idx] <= hit ? new_conf : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pf_valid <= 1'b0;
      pf_addr  <= '0;
    end else if (issue && slot_free) begin
      pf_valid <= 1'b1;
      pf_addr  <= target;
    end else if (pf_ready) begin
      pf_valid <= 1'b0;
    end
  end

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid && !pf_ready |=> pf_valid && $stable(pf_addr));

  assert_miss_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid && !hit && slot_free |=> !pf_valid);

  assert_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
    issue && slot_free |=> pf_valid &&
      (pf_addr[ADDR_W-1:LINE_SH] != $past(ld_addr[ADDR_W-1:LINE_SH])));

  assert_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    issue && slot_free |=> ($signed(pf_addr - $past(ld_addr)) <= MAX_STRIDE) &&
                          ($signed(pf_addr - $past(ld_addr)) >= -MAX_STRIDE));

  assert_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pf_valid) |-> $past(ld_valid));
endmodule

// File: tb/sim_stride_prefetcher.sv
module sim_stride_prefetcher;
  logic clk = 0, rst_n = 0, ld_valid = 0, pf_ready = 1;
  logic [31:0] ld_ip = 0, ld_addr = 0;
  logic pf_valid;
  logic [31:0] pf_addr;
  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  stride_prefetcher u0 (.clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ip(ld_ip),
    .ld_addr(ld_addr), .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr));

  task automatic chk(input bit ok, input string req, input logic [32:0] act, input logic [32:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; ld_valid = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  // one load; returns after the cycle in which its prefetch would appear
  task automatic load(input logic [31:0] ip, input logic [31:0] a);
    @(negedge clk); ld_valid = 1; ld_ip = ip; ld_addr = a;
    @(negedge clk); ld_valid = 0;
  endtask

  task automatic expect_pf(input bit e, input logic [31:0] ea, input string req);
    chk(pf_valid == e && (!e || pf_addr == ea), req, {pf_valid, pf_addr}, {e, ea});
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int strides [14] = '{8, -8, 0, 64, -64, 100, -1000, 2047, 2048, -2048, 2049, -2049, 4000, 1};
    logic [31:0] base, a, pa;
    bit e;

    do_reset();
    chk(pf_valid == 0, "R1 reset", {32'd0, pf_valid}, 33'd0);

    // R5 R6 R7 R8 R9 R11 sweep over strides
    foreach (strides[j]) begin
      int s;
      s = strides[j];
      do_reset();
      base = (j % 2 == 0) ? 32'h8000_0030 : 32'h0000_0830;
      for (int k = 0; k < 8; k++) begin
        a  = base + 32'(k * s);
        pa = a + 32'(s);
        e  = (k >= 3) && (s != 0) && (s >= -2048) && (s <= 2048) && (pa[31:6] != a[31:6]);
        load(32'h0000_0120 + 32'(j), a);
        expect_pf(e, pa, $sformatf("R5/R6/R7/R8/R9 stride %0d k %0d", s, k));
        @(negedge clk);
        chk(pf_valid == 0, "R11 drop after handshake", {32'd0, pf_valid}, 33'd0);
      end
    end

    // R3 interleaved instruction pointers
    do_reset();
    for (int k = 0; k < 6; k++) begin
      a = 32'h4000_0000 + 32'(k * 128);
      load(32'h0000_0051, a);
      expect_pf(k >= 3, a + 32'd128, "R3 ip A");
      a = 32'h5000_0000 - 32'(k * 256);
      load(32'h0000_0072, a);
      expect_pf(k >= 3, a - 32'd256, "R3 ip B");
    end

    // R4 eviction by aliasing pointer
    do_reset();
    for (int k = 0; k < 4; k++) begin
      a = 32'h2000_0000 + 32'(k * 512);
      load(32'h0000_0013, a);
      expect_pf(k >= 3, a + 32'd512, "R4 train C");
    end
    load(32'h0000_0023, 32'h3000_0000);
    expect_pf(0, 0, "R4 alias D miss");
    for (int k = 4; k < 8; k++) begin
      a = 32'h2000_0000 + 32'(k * 512);
      load(32'h0000_0013, a);
      expect_pf(k >= 7, a + 32'd512, "R4 retrain C");
    end

    // R5 stride change resets confidence
    do_reset();
    a = 32'h1000_0000;
    for (int k = 0; k < 4; k++) begin
      load(32'h0000_0035, a);
      expect_pf(k >= 3, a + 32'd128, "R5 first stride");
      a = a + 32'd128;
    end
    a = a + 32'd128;  // now stride 256
    for (int k = 0; k < 4; k++) begin
      load(32'h0000_0035, a);
      expect_pf(k >= 2, a + 32'd256, "R5 after stride change");
      a = a + 32'd256;
    end

    // R10 stall: hold and drop, training continues
    do_reset();
    @(negedge clk); pf_ready = 0;
    for (int k = 0; k < 4; k++) load(32'h0000_0046, 32'h6000_0000 + 32'(k * 1024));
    expect_pf(1, 32'h6000_1000, "R10 first stalled prefetch");
    load(32'h0000_0046, 32'h6000_1000);
    expect_pf(1, 32'h6000_1000, "R10 held while new dropped");
    @(negedge clk); @(negedge clk);
    expect_pf(1, 32'h6000_1000, "R10 still held");
    pf_ready = 1;
    @(negedge clk);
    chk(pf_valid == 0, "R10 released after handshake", {32'd0, pf_valid}, 33'd0);
    load(32'h0000_0046, 32'h6000_1400);
    expect_pf(1, 32'h6000_1800, "R10 training continued");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule